// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block produces the address sequence for a four-beat burst. A load strobe captures a start address. Each later cycle with the advance input high moves the burst on by one beat. The upper address bits stay fixed from the load. Only the low two bits move through the burst, in an order chosen by a static mode input. That order is either a linear count that wraps modulo four, or an interleaved order where the low bits are the start value XORed with the beat number.

The address and the beat index both come straight from registers. A memory controller can place the block beside its address register. It pulses the load strobe when an access is accepted, then raises advance once per beat it consumes. Holding advance low parks the burst on the current address for as long as needed.

Top module: `bcnt_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) makes addr_o and beat_o zero after that edge.
- R2: With ld_i high and rst low at an edge, addr_o equals ld_addr_i and beat_o equals 0 after that edge, whatever the value of adv_i.
- R3: With adv_i high and ld_i and rst low at an edge, beat_o increases by one modulo 4.
- R4: With adv_i, ld_i and rst all low at an edge, addr_o and beat_o keep their values, so the burst is suspended.
- R5: When mode_i is 0 (linear), the low two bits of addr_o equal (start low bits + beat_o) modulo 4.
- R6: When mode_i is 1 (interleaved), the low two bits of addr_o equal start low bits XOR beat_o.
- R7: Bits above the low two bits of addr_o equal those of the last loaded address for the whole burst.
- R8: An advance taken while beat_o is 3 returns addr_o to the start address, with beat_o 0.
- R9: A load in the middle of a burst abandons it and restarts from the new address at beat 0.
- R10: Reset takes priority over a load presented at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_i | input | 1 | Load strobe: start a new burst |
| ld_addr_i | input | ADDR_W | Start address captured on load |
| adv_i | input | 1 | Advance the burst by one beat |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address (registered) |
| beat_o | output | BEAT_W | Beat index since the load (registered) |

## Verification
The step-by-step order properties assume that mode_i holds one value from a load until the next load. A step is checked against the order the mode selects, so a mode change in the middle of a burst would mix the two orders. The stimulus changes mode only in a cycle that also carries a load, or while reset is held. The load and reset properties accept any values on the other inputs, so the bench sets adv_i high during loads and resets on purpose to check that those cycles ignore it.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bcnt_base_reg.sv
// Holds the start address of the current burst.
module bcnt_base_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (ld_i) base_q <= ld_addr_i;
  end

  assign base_o = base_q;
endmodule

// File: rtl/bcnt_beat_ctr.sv
// Wrapping beat index: cleared by reset or load, stepped by advance.
module bcnt_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic [BEAT_W-1:0] beat_nxt_o
);
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_inc;

  assign beat_inc = beat_q + BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)        beat_q <= '0;
    else if (ld_i)  beat_q <= '0;
    else if (adv_i) beat_q <= beat_inc;
  end

  assign beat_o     = beat_q;
  assign beat_nxt_o = beat_inc;
endmodule

// File: rtl/bcnt_order_map.sv
// Maps a beat index onto low address bits in the chosen order.
module bcnt_order_map
  import bcnt_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              mode_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;
  order_e            ord;

  assign ord     = order_e'(mode_i);
  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    case (ord)
      ORD_LINEAR: low_o = lin_low;
      default:    low_o = ilv_low;
    endcase
  end
endmodule

// File: rtl/bcnt_top.sv
// Burst address sequencer top: registered address and beat outputs.
module bcnt_top #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [ADDR_W-1:0] addr_q;

  bcnt_base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk(clk), .rst(rst), .ld_i(ld_i), .ld_addr_i(ld_addr_i), .base_o(base)
  );

  bcnt_beat_ctr #(.BEAT_W(BEAT_W)) beat_i (
    .clk(clk), .rst(rst), .ld_i(ld_i), .adv_i(adv_i),
    .beat_o(beat_o), .beat_nxt_o(beat_nxt)
  );

  bcnt_order_map #(.BEAT_W(BEAT_W)) map_i (
    .start_i(base[BEAT_W-1:0]), .beat_i(beat_nxt), .mode_i(mode_i), .low_o(low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (ld_i)  addr_q <= ld_addr_i;
    else if (adv_i) addr_q <= {base[ADDR_W-1:BEAT_W], low_nxt};
  end

  assign addr_o = addr_q;

  if (HI_W < 1) begin : g_bad_width
    initial $error("bcnt_top: ADDR_W must exceed BEAT_W");
  end
endmodule

// File: rtl/bcnt_chk.sv
// Property checker bound to bcnt_top.
module bcnt_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_i,
  input logic [ADDR_W-1:0] ld_addr_i,
  input logic              adv_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] lo;
  logic [ADDR_W-BEAT_W-1:0] hi;
  assign lo = addr_o[BEAT_W-1:0];
  assign hi = addr_o[ADDR_W-1:BEAT_W];

  // R1 / R10
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (addr_o == '0 && beat_o == '0));

  // R2
  p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_i)) |-> (addr_o == $past(ld_addr_i) && beat_o == '0));

  // R3
  p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_i) && $past(adv_i)) |-> beat_o == BEAT_W'($past(beat_o) + 1'b1));

  // R4
  p_suspend_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_i) && !$past(adv_i)) |-> ($stable(addr_o) && $stable(beat_o)));

  // R5
  p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_i) && $past(adv_i) && !$past(mode_i))
      |-> lo == BEAT_W'($past(lo) + 1'b1));

  // R6
  p_ilv_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_i) && $past(adv_i) && $past(mode_i))
      |-> (lo ^ $past(lo)) == (beat_o ^ $past(beat_o)));

  // R7
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_i)) |-> $stable(hi));
endmodule

bind bcnt_top bcnt_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk(clk), .rst(rst), .ld_i(ld_i), .ld_addr_i(ld_addr_i), .adv_i(adv_i),
  .mode_i(mode_i), .addr_o(addr_o), .beat_o(beat_o)
);

// File: tb/bcnt_top_tb_top.sv
module bcnt_top_tb_top;
  localparam int AW = 16;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic          adv_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] beat_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bcnt_top #(.ADDR_W(AW), .BEAT_W(BW)) dut_i (
    .clk(clk), .rst(rst), .ld_i(ld_i), .ld_addr_i(ld_addr_i),
    .adv_i(adv_i), .mode_i(mode_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  // Expected address from the start address, beat and order.
  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] st, int beat, logic md);
    logic [BW-1:0] s, b;
    s = st[BW-1:0];
    b = BW'(beat);
    return {st[AW-1:BW], md ? (s ^ b) : BW'(s + b)};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [AW-1:0] ea, int eb);
    n_chk++;
    if (addr_o !== ea || beat_o !== BW'(eb)) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_o, beat_o, ea, eb);
    end
  endtask

  task automatic do_load(logic [AW-1:0] a, logic md);
    ld_i = 1'b1; ld_addr_i = a; mode_i = md; adv_i = 1'b1;  // advance must be ignored
    cyc();
    ld_i = 1'b0; adv_i = 1'b0;
    check("R2 load", a, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; ld_i = 1'b0; adv_i = 1'b1;
    cyc(); cyc();
    check("R1 reset", '0, 0);
    rst = 1'b0; adv_i = 1'b0;
  endtask

  task automatic t_burst(logic [AW-1:0] st, logic md);
    do_load(st, md);
    for (int k = 1; k <= 4; k++) begin
      adv_i = 1'b1;
      cyc();
      if (k == 4)      check("R8 wrap R3", st, 0);
      else if (md)     check("R6 interleaved R3 R7", exp_addr(st, k, md), k);
      else             check("R5 linear R3 R7", exp_addr(st, k, md), k);
    end
    adv_i = 1'b0;
  endtask

  task automatic t_suspend();
    logic [AW-1:0] st = 16'h7E02;
    do_load(st, 1'b0);
    adv_i = 1'b1; cyc(); adv_i = 1'b0;
    check("R5 step before suspend", exp_addr(st, 1, 1'b0), 1);
    for (int k = 0; k < 3; k++) begin
      cyc();
      check("R4 suspend", exp_addr(st, 1, 1'b0), 1);
    end
    adv_i = 1'b1; cyc(); adv_i = 1'b0;
    check("R3 resume", exp_addr(st, 2, 1'b0), 2);
  endtask

  task automatic t_reload();
    logic [AW-1:0] a = 16'h1233;
    logic [AW-1:0] b = 16'hC0D1;
    do_load(a, 1'b1);
    adv_i = 1'b1; cyc(); cyc();
    check("R6 mid burst", exp_addr(a, 2, 1'b1), 2);
    ld_i = 1'b1; ld_addr_i = b; mode_i = 1'b0;
    cyc();
    ld_i = 1'b0;
    check("R9 reload", b, 0);
    cyc();
    adv_i = 1'b0;
    check("R9 new burst step", exp_addr(b, 1, 1'b0), 1);
  endtask

  task automatic t_reset_over_load();
    do_load(16'hBEEF, 1'b0);
    adv_i = 1'b1; cyc(); adv_i = 1'b0;
    rst = 1'b1; ld_i = 1'b1; ld_addr_i = 16'h5555;
    cyc();
    rst = 1'b0; ld_i = 1'b0;
    check("R10 reset wins", '0, 0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    for (int s = 0; s < 4; s++) t_burst(AW'(16'hA5C0 | s), 1'b0);
    for (int s = 0; s < 4; s++) t_burst(AW'(16'h3F08 | s), 1'b1);
    t_suspend();
    t_reload();
    t_reset_over_load();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual done=0 expected done=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule